// File: doc/BRIEF.md
# Phase-Frequency Detector with Fast Pump Path and Lock Flag

This block compares the rising edges of two divider outputs, a main (VCO) divider and a reference divider. It turns the phase difference between them into charge-pump requests. The divider signals are taken as levels that are synchronous to a sample clock, and the block detects their rising edges internally.

When the reference edge comes first, a source request (`up`) is raised. When the main edge comes first, a sink request (`dn`) is raised. The request then holds until the later edge arrives. Once both requests are high, both are cleared together after a fixed number of cycles. This overlap keeps the gain linear near zero phase error, and it also gives every comparison a pulse of at least one cycle.

Two pump outputs are produced:
- A primary pump output, driven whenever the block is powered.
- A fast pump output, gated by a resynchronised request line. The gate changes only while no pulse is in flight. A loop filter can therefore switch to a wide bandwidth for channel changes and back to a narrow one when settled, without truncating a correction pulse.

A lock monitor measures the one-sided width of each comparison in clock cycles. It raises a flag when that width is below a window. When the monitor is disabled the flag is held high. Power is on only when a pin and a programmed bit are both high. Power state changes also wait for an idle detector.

Top module: `pfd_lock_top`

## Requirements
- R1: A reference rise seen at clock edge k, followed by a main rise seen d cycles later, gives `up_main` high for exactly d+CLR_DLY consecutive cycles and `dn_main` high for exactly CLR_DLY cycles. Each output goes high at the first clock edge that sees its input high.
- R2: A main rise followed d cycles later by a reference rise gives `dn_main` high for d+CLR_DLY cycles and `up_main` high for CLR_DLY cycles.
- R3: Rises on both inputs at the same clock edge give one pulse on each of `up_main` and `dn_main`, each exactly CLR_DLY cycles long (CLR_DLY is at least 1).
- R4: `up_main` and `dn_main` are never high together for more than CLR_DLY consecutive cycles.
- R5: When the fast path is enabled, `up_fast` and `dn_fast` equal `up_main` and `dn_main`. When it is disabled, both fast outputs stay low.
- R6: A change on `fast_req` only takes effect at a clock edge where no pulse was active. A pulse already in flight keeps the fast-path state it started with.
- R7: The detector runs only while `pwr_pin` and `pwr_bit` are both 1. While it is off, divider edges produce no pulses. A power-off request during a pulse lets that pulse finish in full.
- R8: With `lock_en` = 0, `lock_flag` is 1 at all times.
- R9: With `lock_en` = 1, `lock_flag` is updated at the end of each comparison. It is 1 when the one-sided pulse width (in cycles) is below LOCK_WIN and 0 otherwise. It is 0 after reset and while powered down.
- R10: During reset all pump outputs are 0, and `lock_flag` is 0 when `lock_en` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_div | input | 1 | Reference divider output level, synchronous to clk |
| main_div | input | 1 | Main divider output level, synchronous to clk |
| fast_req | input | 1 | Fast pump path request, asynchronous |
| pwr_pin | input | 1 | Hardware power-on request, active high |
| pwr_bit | input | 1 | Programmed power-on bit, active high |
| lock_en | input | 1 | Programmed lock-monitor enable |
| up_main | output | 1 | Primary pump source request |
| dn_main | output | 1 | Primary pump sink request |
| up_fast | output | 1 | Fast pump source request |
| dn_fast | output | 1 | Fast pump sink request |
| lock_flag | output | 1 | Lock indication (1 = locked or monitor off) |

## Verification
The hardest situation to reach is a control change that lands in the middle of a correction pulse. The fast-path request might flip, or power might be withdrawn, while one request is already high and the other divider edge has not yet arrived. The bench uses a long edge separation so that a pulse is open for several cycles. It toggles `fast_req` or drops `pwr_pin` one cycle into that window. It then counts the pulse cycles on every output to show that the pulse was neither cut nor re-gated. The next comparison shows that the new setting took effect.

// File: rtl/pfd_pkg.sv
package pfd_pkg;

  typedef struct packed {
    logic up;
    logic dn;
  } pump_t;

  // Lock decision: one-sided width strictly below the window.
  function automatic logic err_within(input int unsigned err, input int unsigned win);
    return err < win;
  endfunction

endpackage

// File: rtl/pfd_rise.sv
module pfd_rise (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  output logic rise
);
  logic prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= lvl;
  end

  assign rise = lvl & ~prev_q;
endmodule

// File: rtl/pfd_sync.sv
module pfd_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sr_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (!rst_n) sr_q <= '0;
        else        sr_q <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (!rst_n) sr_q <= '0;
        else        sr_q <= {sr_q[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = sr_q[STAGES-1];
endmodule

// File: rtl/pfd_core.sv
module pfd_core
  import pfd_pkg::*;
#(
  parameter int CLR_DLY = 2
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  ref_rise,
  input  logic  main_rise,
  input  logic  start_ok,
  output pump_t pump,
  output logic  busy
);
  localparam int CW = (CLR_DLY < 2) ? 1 : $clog2(CLR_DLY + 1);

  logic [CW-1:0] clr_cnt;
  logic both, clr_hit, allow;

  assign busy    = pump.up | pump.dn;
  assign both    = pump.up & pump.dn;
  assign clr_hit = both && (clr_cnt == CW'(CLR_DLY - 1));
  // A new comparison may only open while powered; an open one always completes.
  assign allow   = busy | start_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pump    <= '0;
      clr_cnt <= '0;
    end else begin
      if (clr_hit) begin
        pump <= '0;
      end else begin
        pump.up <= pump.up | (ref_rise  & allow);
        pump.dn <= pump.dn | (main_rise & allow);
      end
      if (both && !clr_hit) clr_cnt <= clr_cnt + 1'b1;
      else                  clr_cnt <= '0;
    end
  end
endmodule

// File: rtl/pfd_lock_mon.sv
module pfd_lock_mon
  import pfd_pkg::*;
#(
  parameter int LOCK_WIN = 3
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  run,
  input  pump_t pump,
  output logic  lock_q
);
  localparam int WW = $clog2(LOCK_WIN + 1);

  logic [WW-1:0] err_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      err_cnt <= '0;
      lock_q  <= 1'b0;
    end else begin
      if (pump.up ^ pump.dn) begin
        if (err_cnt != WW'(LOCK_WIN)) err_cnt <= err_cnt + 1'b1;
      end else if (!pump.up) begin
        err_cnt <= '0;
      end
      if (pump.up & pump.dn) lock_q <= err_within(32'(err_cnt), LOCK_WIN);
    end
  end
endmodule

// File: rtl/pfd_lock_top.sv
module pfd_lock_top
  import pfd_pkg::*;
#(
  parameter int CLR_DLY     = 2,
  parameter int LOCK_WIN    = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_div,
  input  logic main_div,
  input  logic fast_req,
  input  logic pwr_pin,
  input  logic pwr_bit,
  input  logic lock_en,
  output logic up_main,
  output logic dn_main,
  output logic up_fast,
  output logic dn_fast,
  output logic lock_flag
);
  // Named internal events, visible to the bound checker.
  logic  ref_rise, main_rise, fast_sync, pwr_req, start_ok, busy;
  logic  run_on, fast_on, lock_q;
  pump_t pump;

  pfd_rise u_ref_rise  (.clk(clk), .rst_n(rst_n), .lvl(ref_div),  .rise(ref_rise));
  pfd_rise u_main_rise (.clk(clk), .rst_n(rst_n), .lvl(main_div), .rise(main_rise));

  pfd_sync #(.STAGES(SYNC_STAGES)) u_fast_sync (
    .clk(clk), .rst_n(rst_n), .d(fast_req), .q(fast_sync)
  );

  assign pwr_req  = pwr_pin & pwr_bit;
  assign start_ok = run_on & pwr_req;

  // Power and fast-path state move only at idle edges.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_on  <= 1'b0;
      fast_on <= 1'b0;
    end else if (!busy) begin
      run_on  <= pwr_req;
      fast_on <= fast_sync;
    end
  end

  pfd_core #(.CLR_DLY(CLR_DLY)) u_core (
    .clk(clk), .rst_n(rst_n), .ref_rise(ref_rise), .main_rise(main_rise),
    .start_ok(start_ok), .pump(pump), .busy(busy)
  );

  pfd_lock_mon #(.LOCK_WIN(LOCK_WIN)) u_lock (
    .clk(clk), .rst_n(rst_n), .run(run_on), .pump(pump), .lock_q(lock_q)
  );

  assign up_main   = pump.up;
  assign dn_main   = pump.dn;
  assign up_fast   = pump.up & fast_on;
  assign dn_fast   = pump.dn & fast_on;
  assign lock_flag = lock_en ? lock_q : 1'b1;
endmodule

// File: rtl/pfd_lock_chk.sv
module pfd_lock_chk #(
  parameter int CLR_DLY = 2
) (
  input logic clk,
  input logic rst_n,
  input logic up_main,
  input logic dn_main,
  input logic up_fast,
  input logic dn_fast,
  input logic lock_en,
  input logic lock_flag,
  input logic busy,
  input logic run_on,
  input logic fast_on
);
  int both_run;

  always_ff @(posedge clk) begin
    if (!rst_n)                   both_run <= 0;
    else if (up_main && dn_main)  both_run <= both_run + 1;
    else                          both_run <= 0;
  end

  assert_overlap_bounded_R4: assert property (@(posedge clk) disable iff (!rst_n)
    both_run <= CLR_DLY);

  assert_fast_up_subset_R5: assert property (@(posedge clk) disable iff (!rst_n)
    up_fast |-> up_main);

  assert_fast_dn_subset_R5: assert property (@(posedge clk) disable iff (!rst_n)
    dn_fast |-> dn_main);

  assert_fast_frozen_in_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(fast_on));

  assert_no_pulse_when_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !run_on |-> (!up_main && !dn_main));

  assert_power_frozen_in_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(busy) |-> $stable(run_on));

  assert_flag_high_when_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !lock_en |-> lock_flag);
endmodule

bind pfd_lock_top pfd_lock_chk #(.CLR_DLY(CLR_DLY)) u_chk (
  .clk(clk), .rst_n(rst_n), .up_main(up_main), .dn_main(dn_main),
  .up_fast(up_fast), .dn_fast(dn_fast), .lock_en(lock_en), .lock_flag(lock_flag),
  .busy(busy), .run_on(run_on), .fast_on(fast_on)
);

// File: tb/test_pfd_lock_top.sv
module test_pfd_lock_top;
  localparam int CLR = 2;
  localparam int WIN = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ref_div = 1'b0, main_div = 1'b0, fast_req = 1'b0;
  logic pwr_pin = 1'b1, pwr_bit = 1'b1, lock_en = 1'b1;
  logic up_main, dn_main, up_fast, dn_fast, lock_flag;

  int n_cmp = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  pfd_lock_top #(.CLR_DLY(CLR), .LOCK_WIN(WIN), .SYNC_STAGES(2)) i_pfd_lock_top (
    .clk(clk), .rst_n(rst_n), .ref_div(ref_div), .main_div(main_div),
    .fast_req(fast_req), .pwr_pin(pwr_pin), .pwr_bit(pwr_bit), .lock_en(lock_en),
    .up_main(up_main), .dn_main(dn_main), .up_fast(up_fast), .dn_fast(dn_fast),
    .lock_flag(lock_flag)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int exp_lock(input int d, input bit en, input bit on);
    if (!en) return 1;
    if (!on) return 0;
    return (d < WIN) ? 1 : 0;
  endfunction

  // mid_op: 0 none, 1 toggle fast_req one cycle in, 2 drop pwr_pin one cycle in
  task automatic pair(input bit lead_ref, input int d, input int mid_op,
                      input bit exp_on, input bit exp_fast, input int lock_exp);
    int cu = 0, cd = 0, cuf = 0, cdf = 0, run_b = 0, max_b = 0;
    int eu, ed;
    string rq;
    for (int i = 0; i < d + CLR + 6; i++) begin
      @(negedge clk);
      cu += int'(up_main); cd += int'(dn_main);
      cuf += int'(up_fast); cdf += int'(dn_fast);
      if (up_main && dn_main) run_b++; else run_b = 0;
      if (run_b > max_b) max_b = run_b;
      if (i == 0) begin if (lead_ref) ref_div = 1'b1; else main_div = 1'b1; end
      if (i == d) begin ref_div = 1'b1; main_div = 1'b1; end
      if (i == 1 && mid_op == 1) fast_req = ~fast_req;
      if (i == 1 && mid_op == 2) pwr_pin = 1'b0;
    end
    eu = exp_on ? (lead_ref ? d + CLR : CLR) : 0;
    ed = exp_on ? (lead_ref ? CLR : d + CLR) : 0;
    rq = (d == 0) ? "R3" : (lead_ref ? "R1" : "R2");
    if (mid_op == 2) rq = "R7";
    if (!exp_on) rq = "R7";
    chk({rq, " up cycles"}, cu, eu);
    chk({rq, " dn cycles"}, cd, ed);
    chk(mid_op == 1 ? "R6 up_fast cycles" : "R5 up_fast cycles", cuf, exp_fast ? eu : 0);
    chk(mid_op == 1 ? "R6 dn_fast cycles" : "R5 dn_fast cycles", cdf, exp_fast ? ed : 0);
    chk("R4 overlap run", (max_b <= CLR) ? 1 : 0, 1);
    chk(lock_en ? "R9 lock_flag" : "R8 lock_flag", int'(lock_flag), lock_exp);
    @(negedge clk);
    ref_div = 1'b0; main_div = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R10 up_main in reset", int'(up_main), 0);
    chk("R10 dn_main in reset", int'(dn_main), 0);
    chk("R10 up_fast in reset", int'(up_fast), 0);
    chk("R10 dn_fast in reset", int'(dn_fast), 0);
    chk("R10 lock_flag in reset", int'(lock_flag), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // Sweep: leader, separation, fast path, monitor enable.
    for (int lr = 0; lr < 2; lr++)
      for (int d = 0; d < 8; d++)
        for (int fm = 0; fm < 2; fm++)
          for (int le = 0; le < 2; le++) begin
            fast_req = fm[0]; lock_en = le[0];
            repeat (6) @(negedge clk);
            pair(lr[0], d, 0, 1'b1, fm[0], exp_lock(d, le[0], 1'b1));
          end

    // R6: fast toggled inside an open pulse, then takes effect on the next one.
    lock_en = 1'b1; fast_req = 1'b0;
    repeat (6) @(negedge clk);
    pair(1'b1, 5, 1, 1'b1, 1'b0, exp_lock(5, 1'b1, 1'b1));
    pair(1'b1, 2, 0, 1'b1, 1'b1, exp_lock(2, 1'b1, 1'b1));
    pair(1'b0, 5, 1, 1'b1, 1'b1, exp_lock(5, 1'b1, 1'b1));
    pair(1'b0, 1, 0, 1'b1, 1'b0, exp_lock(1, 1'b1, 1'b1));

    // R7: power withdrawn mid-pulse; pulse completes, then detector is off.
    pair(1'b1, 4, 2, 1'b1, 1'b0, 0);
    pair(1'b1, 2, 0, 1'b0, 1'b0, 0);
    lock_en = 1'b0;
    pair(1'b0, 3, 0, 1'b0, 1'b0, 1);
    lock_en = 1'b1;
    pwr_pin = 1'b1; pwr_bit = 1'b0;
    repeat (4) @(negedge clk);
    pair(1'b0, 2, 0, 1'b0, 1'b0, 0);
    pwr_bit = 1'b1;
    repeat (4) @(negedge clk);
    pair(1'b0, 2, 0, 1'b1, 1'b0, exp_lock(2, 1'b1, 1'b1));
    pair(1'b1, 0, 0, 1'b1, 1'b0, exp_lock(0, 1'b1, 1'b1));

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule